// File: doc/BRIEF.md
# Programmable bus clock divider

This block takes one fast source clock and produces two clock-enable strobes in that clock's domain. The system bus strobe fires once every N source cycles. N comes from a fixed, non-uniform set of ratios that includes divide-by-5 and divide-by-6 as well as powers of two. The peripheral bus strobe is cascaded from the bus strobe. It fires on one bus strobe out of every M, where M is a power of two, so the peripheral rate is the source rate divided by N times M.

Software writes the two divide selects through a single write strobe. Each field has its own field-enable bit. A written value is held as pending and becomes active only at the next bus strobe. At that point both dividers restart together, so no period in progress is cut short or stretched. The read ports always show the active selects. The block does not check whether a combination of ratios makes sense for the peripherals attached to it.

Top module: `bus_clkdiv`

## Requirements
- R1: After reset the active bus select reads 000 and the active peripheral select reads 00. `bus_en` and `per_en` are high on every source cycle until a different setting becomes active.
- R2: The bus select encodes the divide ratio as 000=1, 001=2, 010=4, 011=5, 100=6, 101=8, 110=16, 111=32. Every encoding is accepted and applied without any check.
- R3: `bus_en` is high for exactly one source cycle in every N. The N-1 cycles between two pulses are low, where N is the active bus ratio.
- R4: The peripheral select encodes 00=1, 01=2, 10=4, 11=8 bus pulses per `per_en` pulse. The peripheral period in source cycles is therefore the bus ratio times this value.
- R5: `per_en` is never high on a cycle where `bus_en` is low.
- R6: A value written in cycle W becomes active at the first `bus_en` cycle after W. The read ports show it from the cycle after that pulse. The bus period that is running when the write arrives completes at its old length.
- R7: `cfg_field_en` bit 0 enables the write of the bus field and bit 1 enables the write of the peripheral field. A field whose bit is clear keeps its previous value, and a strobe with both bits clear changes nothing.
- R8: When the active setting changes at a bus pulse, the peripheral count restarts. The first `bus_en` pulse under the new setting also carries `per_en`.
- R9: While both active selects are zero (both ratios 1), `bus_en` and `per_en` are both high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the divide selects |
| cfg_field_en | input | 2 | Field enables: bit 0 bus select, bit 1 peripheral select |
| cfg_bus_div | input | 3 | Bus divide select to write |
| cfg_per_div | input | 2 | Peripheral divide select to write |
| bus_en | output | 1 | One-cycle system bus clock enable |
| per_en | output | 1 | One-cycle peripheral bus clock enable |
| rd_bus_div | output | 3 | Active bus divide select |
| rd_per_div | output | 2 | Active peripheral divide select |

## Verification
The assertions check several rules on every cycle. The bus counter steps down by one between pulses and never exceeds the active ratio. The peripheral count holds between bus pulses and stays within its active ratio. Active selects change only at a bus pulse, pending fields change only under their field enable, and both enables stay high while both ratios are 1. Other behaviour can only be shown by the bench's scenarios against its cycle model: the exact period of each of the eight bus encodings and each of the four peripheral encodings, the old period completing after a late write, and the peripheral restart on the first pulse of a new setting.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int unsigned BUS_CODES = 8;

   // Non-uniform bus ratio decode; the mix of 5 and 6 is why this is a table.
   function automatic int unsigned bus_div_ratio(input int unsigned code);
      case (code)
         0:       return 1;
         1:       return 2;
         2:       return 4;
         3:       return 5;
         4:       return 6;
         5:       return 8;
         6:       return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int unsigned max_bus_ratio();
      int unsigned m;
      m = 1;
      for (int unsigned i = 0; i < BUS_CODES; i++) begin
         if (bus_div_ratio(i) > m) m = bus_div_ratio(i);
      end
      return m;
   endfunction

endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs #(
   parameter int unsigned BUS_SEL_W = 3,
   parameter int unsigned PER_SEL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic [1:0]           wr_field_en,
   input  logic [BUS_SEL_W-1:0] wr_bus_sel,
   input  logic [PER_SEL_W-1:0] wr_per_sel,
   input  logic                 boundary,
   output logic [BUS_SEL_W-1:0] pend_bus,
   output logic [PER_SEL_W-1:0] pend_per,
   output logic [BUS_SEL_W-1:0] act_bus,
   output logic [PER_SEL_W-1:0] act_per,
   output logic                 changed
);

   localparam int unsigned FLD_BUS = 0;
   localparam int unsigned FLD_PER = 1;

   logic wr_bus_hit;
   logic wr_per_hit;

   assign wr_bus_hit = wr_stb && wr_field_en[FLD_BUS];
   assign wr_per_hit = wr_stb && wr_field_en[FLD_PER];

   // pending copies, written by software at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_bus <= '0;
         pend_per <= '0;
      end else begin
         if (wr_bus_hit) pend_bus <= wr_bus_sel;
         if (wr_per_hit) pend_per <= wr_per_sel;
      end
   end

   // active copies, moved only at a bus boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_bus <= '0;
         act_per <= '0;
      end else if (boundary) begin
         act_bus <= pend_bus;
         act_per <= pend_per;
      end
   end

   assign changed = (pend_bus != act_bus) || (pend_per != act_per);

   assert_active_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ($stable(act_bus) && $stable(act_per)));

   assert_bus_field_mask_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && wr_field_en[FLD_BUS]) |=> $stable(pend_bus));

   assert_per_field_mask_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && wr_field_en[FLD_PER]) |=> $stable(pend_per));

endmodule

// File: rtl/clkdiv_bus_stage.sv
module clkdiv_bus_stage #(
   parameter int unsigned BUS_SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BUS_SEL_W-1:0] next_sel,
   input  logic [BUS_SEL_W-1:0] act_sel,
   output logic                 bus_en
);

   localparam int unsigned NUM_SEL = 1 << BUS_SEL_W;
   localparam int unsigned MAX_DIV = clkdiv_pkg::max_bus_ratio();
   localparam int unsigned CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

   logic [CNT_W-1:0] ratio_m1 [NUM_SEL];
   logic [CNT_W-1:0] cnt;

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_ratio
      assign ratio_m1[g] = CNT_W'(clkdiv_pkg::bus_div_ratio(g) - 1);
   end

   assign bus_en = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (bus_en) begin
         cnt <= ratio_m1[next_sel];
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assert_count_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   assert_count_within_ratio_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= ratio_m1[act_sel]);

endmodule

// File: rtl/clkdiv_per_stage.sv
module clkdiv_per_stage #(
   parameter int unsigned PER_SEL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 restart,
   input  logic [PER_SEL_W-1:0] next_sel,
   input  logic [PER_SEL_W-1:0] act_sel,
   output logic                 per_en
);

   localparam int unsigned CNT_W = (1 << PER_SEL_W) - 1;

   logic [CNT_W:0]   next_lim;
   logic [CNT_W:0]   act_lim;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] pcnt;

   assign next_lim = (CNT_W+1)'(1) << next_sel;
   assign act_lim  = (CNT_W+1)'(1) << act_sel;
   assign reload   = CNT_W'(next_lim - 1'b1);

   assign per_en = bus_en && (pcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (bus_en) begin
         if (restart)           pcnt <= '0;
         else if (pcnt == '0)   pcnt <= reload;
         else                   pcnt <= pcnt - 1'b1;
      end
   end

   assert_pcount_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |=> $stable(pcnt));

   assert_pcount_within_ratio_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, pcnt} < act_lim);

endmodule

// File: rtl/bus_clkdiv.sv
module bus_clkdiv #(
   parameter int unsigned BUS_SEL_W  = 3,
   parameter int unsigned PER_SEL_W  = 2,
   parameter bit          PER_DIV_EN = 1'b1
) (
   input  logic                 clk_src,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [1:0]           cfg_field_en,
   input  logic [BUS_SEL_W-1:0] cfg_bus_div,
   input  logic [PER_SEL_W-1:0] cfg_per_div,
   output logic                 bus_en,
   output logic                 per_en,
   output logic [BUS_SEL_W-1:0] rd_bus_div,
   output logic [PER_SEL_W-1:0] rd_per_div
);

   if (BUS_SEL_W != 3) begin : g_bad_bus_w
      $error("bus_clkdiv: BUS_SEL_W must be 3 to match the ratio table");
   end
   if (PER_SEL_W < 1 || PER_SEL_W > 3) begin : g_bad_per_w
      $error("bus_clkdiv: PER_SEL_W must lie in 1..3");
   end

   logic [BUS_SEL_W-1:0] pend_bus;
   logic [PER_SEL_W-1:0] pend_per;
   logic [BUS_SEL_W-1:0] act_bus;
   logic [PER_SEL_W-1:0] act_per;
   logic                 cfg_changed;
   logic                 bus_pulse;

   clkdiv_cfg_regs #(
      .BUS_SEL_W (BUS_SEL_W),
      .PER_SEL_W (PER_SEL_W)
   ) u_cfg (
      .clk         (clk_src),
      .rst_n       (rst_n),
      .wr_stb      (cfg_wr),
      .wr_field_en (cfg_field_en),
      .wr_bus_sel  (cfg_bus_div),
      .wr_per_sel  (cfg_per_div),
      .boundary    (bus_pulse),
      .pend_bus    (pend_bus),
      .pend_per    (pend_per),
      .act_bus     (act_bus),
      .act_per     (act_per),
      .changed     (cfg_changed)
   );

   clkdiv_bus_stage #(
      .BUS_SEL_W (BUS_SEL_W)
   ) u_bus (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .next_sel (pend_bus),
      .act_sel  (act_bus),
      .bus_en   (bus_pulse)
   );

   if (PER_DIV_EN) begin : g_per_div
      clkdiv_per_stage #(
         .PER_SEL_W (PER_SEL_W)
      ) u_per (
         .clk      (clk_src),
         .rst_n    (rst_n),
         .bus_en   (bus_pulse),
         .restart  (cfg_changed),
         .next_sel (pend_per),
         .act_sel  (act_per),
         .per_en   (per_en)
      );
   end else begin : g_per_tied
      assign per_en = bus_pulse;
   end

   assign bus_en     = bus_pulse;
   assign rd_bus_div = act_bus;
   assign rd_per_div = act_per;

   assert_unity_both_high_R9 : assert property (@(posedge clk_src) disable iff (!rst_n)
      (rd_bus_div == '0 && rd_per_div == '0) |-> (bus_en && per_en));

endmodule

// File: tb/bus_clkdiv_test.sv
`timescale 1ns/1ps
module bus_clkdiv_test;

   logic       clk_src = 1'b0;
   logic       rst_n   = 1'b0;
   logic       cfg_wr  = 1'b0;
   logic [1:0] cfg_field_en = 2'b00;
   logic [2:0] cfg_bus_div  = 3'd0;
   logic [1:0] cfg_per_div  = 2'd0;
   logic       bus_en, per_en;
   logic [2:0] rd_bus_div;
   logic [1:0] rd_per_div;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int bus_tab [8] = '{1, 2, 4, 5, 6, 8, 16, 32};

   // reference model state (integers only)
   int m_left    = 0;   // source cycles until next bus pulse
   int m_pleft   = 0;   // bus pulses until next peripheral pulse
   int m_pb = 0, m_pp = 0, m_ab = 0, m_ap = 0;

   always #4 clk_src = ~clk_src;   // 125 MHz

   bus_clkdiv uut (
      .clk_src      (clk_src),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_field_en (cfg_field_en),
      .cfg_bus_div  (cfg_bus_div),
      .cfg_per_div  (cfg_per_div),
      .bus_en       (bus_en),
      .per_en       (per_en),
      .rd_bus_div   (rd_bus_div),
      .rd_per_div   (rd_per_div)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // model advance at each rising edge
   always @(posedge clk_src) begin
      if (!rst_n) begin
         m_left = 0; m_pleft = 0;
         m_pb = 0; m_pp = 0; m_ab = 0; m_ap = 0;
      end else begin
         int nb, np;
         nb = m_pb; np = m_pp;
         if (cfg_wr && cfg_field_en[0]) nb = cfg_bus_div;
         if (cfg_wr && cfg_field_en[1]) np = cfg_per_div;
         if (m_left == 0) begin
            if (m_pb != m_ab || m_pp != m_ap) m_pleft = 0;
            else if (m_pleft == 0)            m_pleft = (1 << m_pp) - 1;
            else                              m_pleft = m_pleft - 1;
            m_ab = m_pb; m_ap = m_pp;
            m_left = bus_tab[m_pb] - 1;
         end else begin
            m_left = m_left - 1;
         end
         m_pb = nb; m_pp = np;
      end
   end

   // compare on every falling edge
   always @(negedge clk_src) begin
      if (rst_n) begin
         chk("R3 bus_en vs model", int'(bus_en), int'(m_left == 0));
         chk("R4 per_en vs model", int'(per_en), int'(m_left == 0 && m_pleft == 0));
         chk("R6 rd_bus_div vs model", int'(rd_bus_div), m_ab);
         chk("R6 rd_per_div vs model", int'(rd_per_div), m_ap);
         chk("R5 per_en without bus_en", int'(per_en && !bus_en), 0);
      end
   end

   task automatic write_cfg(input logic [1:0] fe, input int b, input int p);
      @(negedge clk_src);
      cfg_wr = 1'b1; cfg_field_en = fe;
      cfg_bus_div = 3'(b); cfg_per_div = 2'(p);
      @(negedge clk_src);
      cfg_wr = 1'b0; cfg_field_en = 2'b00;
   endtask

   task automatic wait_bus();
      do @(negedge clk_src); while (!bus_en);
   endtask

   task automatic wait_per();
      do @(negedge clk_src); while (!per_en);
   endtask

   task automatic bus_period(output int n);
      wait_bus();
      n = 0;
      do begin @(negedge clk_src); n++; end while (!bus_en);
   endtask

   task automatic per_period(output int n);
      wait_per();
      n = 0;
      do begin @(negedge clk_src); n++; end while (!per_en);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (4) @(negedge clk_src);
      rst_n = 1'b1;

      // R1 / R9: reset state, both enables high every cycle
      for (int i = 0; i < 4; i++) begin
         @(negedge clk_src);
         chk("R1 rd_bus_div after reset", int'(rd_bus_div), 0);
         chk("R1 rd_per_div after reset", int'(rd_per_div), 0);
         chk("R9 bus_en at unity", int'(bus_en), 1);
         chk("R9 per_en at unity", int'(per_en), 1);
      end

      // R2 / R3: every bus encoding gives its period
      for (int s = 0; s < 8; s++) begin
         write_cfg(2'b01, s, 0);
         repeat (2) wait_bus();
         bus_period(n);
         chk($sformatf("R2 bus period code %0d", s), n, bus_tab[s]);
      end

      // R4: peripheral ratio cascaded on a divide-by-5 bus
      for (int p = 0; p < 4; p++) begin
         write_cfg(2'b11, 3, p);
         repeat (2) wait_bus();
         per_period(n);
         per_period(n);
         chk($sformatf("R4 per period code %0d on bus/5", p), n, 5 * (1 << p));
      end

      // R7: only the peripheral field enabled, bus field keeps 3
      write_cfg(2'b10, 7, 1);
      repeat (3) wait_bus();
      chk("R7 bus field unchanged", int'(rd_bus_div), 3);
      chk("R7 per field written", int'(rd_per_div), 1);
      write_cfg(2'b00, 6, 2);
      repeat (3) wait_bus();
      chk("R7 no-field write bus", int'(rd_bus_div), 3);
      chk("R7 no-field write per", int'(rd_per_div), 1);

      // R6: late write does not cut the running /32 period
      write_cfg(2'b01, 7, 0);
      repeat (2) wait_bus();
      wait_bus();
      write_cfg(2'b01, 1, 0);
      chk("R6 old select still active", int'(rd_bus_div), 7);
      n = 2;
      do begin @(negedge clk_src); n++; end while (!bus_en);
      chk("R6 running period completes", n, 32);
      n = 0;
      do begin @(negedge clk_src); n++; end while (!bus_en);
      chk("R6 new period after boundary", n, 2);

      // R8: peripheral restart on setting change
      write_cfg(2'b10, 0, 0);
      repeat (3) wait_bus();
      write_cfg(2'b10, 0, 3);
      do @(negedge clk_src); while (rd_per_div != 2'd3);
      wait_bus();
      chk("R8 first new bus pulse carries per_en", int'(per_en), 1);

      // R2 any combination accepted: bus /1 with per /8
      write_cfg(2'b11, 0, 3);
      repeat (3) wait_bus();
      per_period(n);
      per_period(n);
      chk("R2 bus/1 per/8 accepted", n, 8);

      // R9: back to unity
      write_cfg(2'b11, 0, 0);
      repeat (12) @(negedge clk_src);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk_src);
         chk("R9 bus_en unity", int'(bus_en), 1);
         chk("R9 per_en unity", int'(per_en), 1);
      end

      finish_run();
   end

endmodule